// File: doc/BRIEF.md
# Rate-controlled Ethernet frame generator

This block sends a programmed number of identical Ethernet frames on a byte-wide transmit stream. It puts out one byte per 125 MHz clock, with a data byte and a valid strobe. The frame contents come from configuration inputs: destination and source addresses, a type field, a payload length, and an optional fixed 4-byte tag word. The payload is a counting pattern that restarts at zero in every frame. The frame check sequence is computed on the fly.

The block sizes the idle time after each frame from a requested load percentage L. The stream therefore carries exactly that share of the line rate: each frame of S bytes is followed by 12 + floor((12 + S)(100 − L) / L) idle cycles. A start pulse latches the whole configuration. A bit-serial divider then computes the gap once. An optional start delay runs alongside the divider, and the first frame starts only when both have finished.

A status output reports disabled, transmitting or done. Dropping the enable input stops the run cleanly at the next frame boundary.

Top module: `frame_load_gen`

## Requirements
- R1: After reset, status is 0 (disabled), tx_en is low and load_err is low.
- R2: A frame is 7 bytes 0x55, then 0xD5, then the destination address (bits 47:40 first), the source address (bits 47:40 first), the type field (bits 15:8 first), then payload_len payload bytes of value 0x00, 0x01, 0x02 and so on, then 4 check bytes. An untagged frame is therefore 26 + payload_len bytes long, and tx_en stays high for exactly that many cycles.
- R3: With tag_en high, the 4 bytes of tag_word (bits 31:24 first) follow the source address, ahead of the type field. The frame grows by 4 bytes.
- R4: The check bytes are the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) over the bytes from the destination address through the last payload byte, sent bits 7:0 first. Running the same CRC over those bytes plus the check bytes leaves 0xDEBB20E3.
- R5: After every frame, tx_en stays low for exactly 12 + floor((12 + S)(100 − L) / L) cycles, where S is the frame length. At L = 100 this is 12 cycles.
- R6: Exactly frame_total frames are sent. Status then reads 2 (done) and tx_en stays low. With frame_total = 0, status goes to done and no frame is sent.
- R7: For a start pulse sampled at edge 0, tx_en first goes high in the cycle after edge max(start_delay, 19) + 1. Here 19 is the number of divider steps with default widths.
- R8: A start pulse with load_pct equal to 0 or above 100 leaves status at disabled, sends nothing and sets load_err. The next accepted start clears load_err.
- R9: If enable drops during a frame, that frame and its gap still complete in full. Status then returns to disabled and no further frame is sent.
- R10: Status reads 1 from an accepted start until the run ends. A start pulse is ignored while enable is low. Clearing enable while done returns status to disabled on the next cycle.
- R11: All configuration inputs are sampled at the accepted start edge. Changing them during a run has no effect on the frames or the gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable |
| start | input | 1 | Start trigger, sampled while disabled or done |
| dst_mac | input | 48 | Destination address |
| src_mac | input | 48 | Source address |
| ether_type | input | 16 | Type field |
| payload_len | input | LEN_W | Payload length in bytes (42 to 1500) |
| tag_en | input | 1 | Insert the 4-byte tag word |
| tag_word | input | 32 | Tag contents |
| load_pct | input | 7 | Requested load, 1 to 100 percent |
| frame_total | input | CNT_W | Number of frames to send |
| start_delay | input | DLY_W | Cycles to hold off the first frame |
| tx_data | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit byte valid |
| status | output | 2 | 0 disabled, 1 transmitting, 2 done |
| load_err | output | 1 | Last start carried an invalid load |

## Verification
The bench first targets the gap arithmetic, with loads of 100 percent (12-cycle minimum), 50 percent on a 1526-byte frame (1550 cycles) and random loads. A divider with an off-by-one step or wrong rounding would give a gap wrong by one or more cycles. It times the start delay below and above the divider latency, which would expose a design that adds the two or ignores one of them. A mid-frame enable drop would show a truncated frame, a missing gap or an extra frame. Zero and out-of-range loads, a zero frame count, and configuration changes during a run would expose a generator that starts anyway, never reaches done, or reads live inputs.

// File: rtl/frame_load_gen.sv
module frame_load_gen #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 16,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [47:0]      dst_mac,
  input  logic [47:0]      src_mac,
  input  logic [15:0]      ether_type,
  input  logic [LEN_W-1:0] payload_len,
  input  logic             tag_en,
  input  logic [31:0]      tag_word,
  input  logic [6:0]       load_pct,
  input  logic [CNT_W-1:0] frame_total,
  input  logic [DLY_W-1:0] start_delay,
  output logic [7:0]       tx_data,
  output logic             tx_en,
  output logic [1:0]       status,
  output logic             load_err
);

  localparam int FS_W  = LEN_W + 1;
  localparam int NUM_W = FS_W + 7;
  localparam int GAP_W = NUM_W + 1;
  localparam int DC_W  = $clog2(NUM_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_FRAME, S_GAP, S_DONE} st_t;

  st_t              st;
  logic [47:0]      da, sa;
  logic [15:0]      et;
  logic [LEN_W-1:0] plen;
  logic             tg_on;
  logic [31:0]      tg;
  logic [6:0]       lp;
  logic [CNT_W-1:0] frames_left;
  logic [DLY_W-1:0] dly;
  logic [DC_W-1:0]  div_cnt;
  logic [NUM_W-1:0] num_q;
  logic [6:0]       rem;
  logic [GAP_W-1:0] gap_len, gcnt;
  logic [FS_W-1:0]  pos;
  logic [31:0]      crc;
  logic             stop_req;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic [FS_W-1:0]  s_in;
  logic [NUM_W-1:0] num_in;
  logic             load_bad, go;
  assign s_in     = FS_W'(26) + FS_W'(payload_len) + (tag_en ? FS_W'(4) : FS_W'(0));
  assign num_in   = NUM_W'(s_in + FS_W'(12)) * NUM_W'(7'd100 - load_pct);
  assign load_bad = (load_pct == 7'd0) || (load_pct > 7'd100);
  assign go       = start && enable && (st == S_IDLE || st == S_DONE);

  logic [7:0] r2;
  logic       ge;
  assign r2 = {rem, num_q[NUM_W-1]};
  assign ge = r2 >= {1'b0, lp};

  logic [FS_W-1:0] pay_lo, fcs_lo, fsize;
  assign pay_lo = tg_on ? FS_W'(26) : FS_W'(22);
  assign fcs_lo = pay_lo + FS_W'(plen);
  assign fsize  = fcs_lo + FS_W'(4);

  logic [7:0]  byte_v;
  logic [31:0] crc_inv;
  assign crc_inv = ~crc;

  always_comb begin
    if (pos < FS_W'(7))                   byte_v = 8'h55;
    else if (pos == FS_W'(7))             byte_v = 8'hD5;
    else if (pos < FS_W'(14))             byte_v = 8'(da >> {FS_W'(13) - pos, 3'b000});
    else if (pos < FS_W'(20))             byte_v = 8'(sa >> {FS_W'(19) - pos, 3'b000});
    else if (pos < pay_lo - FS_W'(2))     byte_v = 8'(tg >> {FS_W'(23) - pos, 3'b000});
    else if (pos == pay_lo - FS_W'(2))    byte_v = et[15:8];
    else if (pos < pay_lo)                byte_v = et[7:0];
    else if (pos < fcs_lo)                byte_v = 8'(pos - pay_lo);
    else                                  byte_v = 8'(crc_inv >> {pos - fcs_lo, 3'b000});
  end

  assign tx_en   = (st == S_FRAME);
  assign tx_data = tx_en ? byte_v : 8'h00;
  assign status  = (st == S_IDLE) ? 2'd0 : (st == S_DONE) ? 2'd2 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  load_err <= 1'b0;
      da <= '0;  sa <= '0;  et <= '0;  plen <= '0;  tg_on <= 1'b0;  tg <= '0;  lp <= '0;
      frames_left <= '0;  dly <= '0;  div_cnt <= '0;  num_q <= '0;  rem <= '0;
      gap_len <= '0;  gcnt <= '0;  pos <= '0;  crc <= '1;  stop_req <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (go) begin
            if (load_bad) begin
              load_err <= 1'b1;
              st <= S_IDLE;
            end else begin
              load_err <= 1'b0;
              da <= dst_mac;  sa <= src_mac;  et <= ether_type;  plen <= payload_len;
              tg_on <= tag_en;  tg <= tag_word;  lp <= load_pct;
              frames_left <= frame_total;  dly <= start_delay;
              num_q <= num_in;  rem <= '0;  div_cnt <= DC_W'(NUM_W);
              stop_req <= 1'b0;
              st <= S_DIV;
            end
          end else if (st == S_DONE && !enable) begin
            st <= S_IDLE;
          end
        end
        S_DIV: begin
          if (!enable) begin
            st <= S_IDLE;
          end else begin
            if (div_cnt != '0) begin
              rem     <= ge ? 7'(r2 - {1'b0, lp}) : r2[6:0];
              num_q   <= {num_q[NUM_W-2:0], ge};
              div_cnt <= div_cnt - 1'b1;
            end
            if (dly != '0) dly <= dly - 1'b1;
            if (div_cnt == '0 && dly == '0) begin
              gap_len <= GAP_W'(num_q) + GAP_W'(12);
              pos <= '0;
              crc <= '1;
              st  <= (frames_left == '0) ? S_DONE : S_FRAME;
            end
          end
        end
        S_FRAME: begin
          if (!enable) stop_req <= 1'b1;
          if (pos >= FS_W'(8) && pos < fcs_lo) crc <= crc_byte(crc, byte_v);
          if (pos == fsize - FS_W'(1)) begin
            st <= S_GAP;
            gcnt <= gap_len;
            frames_left <= frames_left - 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        S_GAP: begin
          if (!enable) stop_req <= 1'b1;
          if (gcnt == GAP_W'(1)) begin
            if (stop_req || !enable) st <= S_IDLE;
            else if (frames_left == '0) st <= S_DONE;
            else begin
              st  <= S_FRAME;
              pos <= '0;
              crc <= '1;
            end
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [3:0] idle_run;
  logic       seen_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (tx_en) begin
        idle_run <= '0;
        seen_frame <= 1'b1;
      end else if (idle_run != 4'hF) begin
        idle_run <= idle_run + 1'b1;
      end
    end
  end

  // R10
  status_enc_chk: assert property (@(posedge clk) disable iff (!rst_n) status != 2'd3);
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) status == 2'd2 |-> !tx_en);
  // R2
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en) |-> tx_data == 8'h55);
  // R5
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && seen_frame) |-> idle_run >= 4'd12);
  // R8
  bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enable && status != 2'd1 && load_bad) |=> (status == 2'd0 && load_err));
  // R10
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && !enable) |=> status == 2'd0);

endmodule

// File: tb/tb_frame_load_gen.sv
module tb_frame_load_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start = 1'b0;
  logic [47:0] dst_mac = '0, src_mac = '0;
  logic [15:0] ether_type = '0;
  logic [10:0] payload_len = '0;
  logic        tag_en = 1'b0;
  logic [31:0] tag_word = '0;
  logic [6:0]  load_pct = '0;
  logic [15:0] frame_total = '0, start_delay = '0;
  logic [7:0]  tx_data;
  logic        tx_en;
  logic [1:0]  status;
  logic        load_err;

  frame_load_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .dst_mac(dst_mac), .src_mac(src_mac), .ether_type(ether_type),
    .payload_len(payload_len), .tag_en(tag_en), .tag_word(tag_word),
    .load_pct(load_pct), .frame_total(frame_total), .start_delay(start_delay),
    .tx_data(tx_data), .tx_en(tx_en), .status(status), .load_err(load_err));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, total_cyc = 0;
  logic [7:0] cap [0:2047];

  logic [47:0] c_da, c_sa;
  logic [15:0] c_et;
  logic [31:0] c_tw;
  bit          c_tag;
  int          c_plen, c_L, c_n, c_D;

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", total_cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic int exp_size();
    return 26 + c_plen + (c_tag ? 4 : 0);
  endfunction

  function automatic int exp_gap();
    int s = exp_size();
    return 12 + ((12 + s) * (100 - c_L)) / c_L;
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    int p0 = c_tag ? 26 : 22;
    if (i < 7) return 8'h55;
    if (i == 7) return 8'hD5;
    if (i < 14) return c_da[8*(13-i) +: 8];
    if (i < 20) return c_sa[8*(19-i) +: 8];
    if (c_tag && i < 24) return c_tw[8*(23-i) +: 8];
    if (i == p0 - 2) return c_et[15:8];
    if (i == p0 - 1) return c_et[7:0];
    return 8'(i - p0);
  endfunction

  task automatic apply_cfg();
    dst_mac = c_da; src_mac = c_sa; ether_type = c_et; payload_len = 11'(c_plen);
    tag_en = c_tag; tag_word = c_tw; load_pct = 7'(c_L);
    frame_total = 16'(c_n); start_delay = 16'(c_D);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic capture_frame(output int len);
    len = 0;
    while (tx_en && len < 2048) begin
      cap[len] = tx_data;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic count_idle(output int idle);
    idle = 0;
    while (!tx_en && status == 2'd1) begin
      idle++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input int len);
    int bad = -1;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] fcs;
    check(len == exp_size(), "R2", "frame length", len, exp_size());
    for (int i = 0; i < len - 4 && i < exp_size() - 4; i++)
      if (bad < 0 && cap[i] !== exp_byte(i)) bad = i;
    check(bad < 0, c_tag ? "R3" : "R2", "header/payload byte",
          bad < 0 ? 0 : cap[bad], bad < 0 ? 0 : exp_byte(bad));
    if (c_tag)
      check({cap[20], cap[21], cap[22], cap[23]} === c_tw, "R3", "tag bytes",
            {cap[20], cap[21], cap[22], cap[23]}, c_tw);
    if (len >= 12) begin
      for (int i = 8; i < len - 4; i++) c = crc_b(c, cap[i]);
      fcs = ~c;
      check({cap[len-1], cap[len-2], cap[len-3], cap[len-4]} === fcs, "R4", "check bytes",
            {cap[len-1], cap[len-2], cap[len-3], cap[len-4]}, fcs);
      for (int i = len - 4; i < len; i++) c = crc_b(c, cap[i]);
      check(c == 32'hDEBB20E3, "R4", "crc residue", c, 32'hDEBB20E3);
    end
  endtask

  task automatic run_case(input bit scramble);
    int cyc = 0, len, idle, got = 0;
    int first = ((c_D > 19) ? c_D : 19) + 1;
    apply_cfg();
    pulse_start();
    if (scramble) begin
      dst_mac = ~c_da; src_mac = '0; ether_type = ~c_et; payload_len = 11'd100;
      tag_en = !c_tag; load_pct = 7'd10; frame_total = 16'd9; start_delay = '0;
    end
    while (!tx_en && status == 2'd1 && cyc < first + 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (c_n == 0) begin
      check(!tx_en && status == 2'd2, "R6", "zero count ends done", status, 2);
      return;
    end
    check(tx_en && cyc == first, "R7", "first byte cycle", cyc, first);
    for (int f = 0; f < c_n && tx_en; f++) begin
      capture_frame(len);
      check_frame(len);
      got++;
      count_idle(idle);
      check(idle == exp_gap(), scramble ? "R11" : "R5", "gap cycles", idle, exp_gap());
    end
    check(got == c_n, scramble ? "R11" : "R6", "frames sent", got, c_n);
    check(status == 2'd2, "R6", "done status", status, 2);
    check(load_err == 1'b0, "R8", "load_err clear after valid start", load_err, 0);
  endtask

  task automatic bad_load(input int L);
    bit saw = 0;
    c_L = L;
    apply_cfg();
    pulse_start();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_en) saw = 1;
    end
    check(!saw && status == 2'd0, "R8", "invalid load stays disabled", status, 0);
    check(load_err == 1'b1, "R8", "load_err set", load_err, 1);
  endtask

  initial begin
    int len, idle;
    bit saw;
    void'($urandom(32'h1F2E3D4C));
    c_da = 48'h0A1B2C3D4E5F; c_sa = 48'h665544332211; c_et = 16'h8892; c_tw = 32'h8100A00B;
    c_tag = 0; c_plen = 42; c_L = 100; c_n = 3; c_D = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 2'd0 && !tx_en, "R1", "reset status/tx_en", {status, tx_en}, 0);
    check(load_err == 1'b0, "R1", "reset load_err", load_err, 0);

    enable = 1'b1;
    run_case(0);
    enable = 1'b0;
    @(negedge clk);
    check(status == 2'd0, "R10", "done to disabled", status, 0);
    enable = 1'b1;

    c_plen = 1500; c_L = 50; c_n = 2; c_D = 5;
    run_case(0);
    check(exp_gap() == 1550, "R5", "half-load gap reference", exp_gap(), 1550);

    c_tag = 1; c_plen = 64; c_L = 75; c_n = 2; c_D = 30;
    run_case(0);

    c_tag = 0; c_plen = 50; c_L = 60; c_n = 0; c_D = 0;
    run_case(0);

    c_n = 1;
    bad_load(0);
    bad_load(101);
    c_L = 80; c_plen = 42;
    run_case(0);

    enable = 1'b0;
    c_L = 100;
    apply_cfg();
    pulse_start();
    saw = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_en || status != 2'd0) saw = 1;
    end
    check(!saw, "R10", "start ignored while disabled", saw, 0);

    enable = 1'b1;
    c_plen = 60; c_L = 100; c_n = 5; c_D = 0;
    apply_cfg();
    pulse_start();
    while (!tx_en) @(negedge clk);
    repeat (10) begin
      cap[0] = 8'h00;
      @(negedge clk);
    end
    enable = 1'b0;
    capture_frame(len);
    check(len + 10 == exp_size(), "R9", "frame completes after enable drop", len + 10, exp_size());
    count_idle(idle);
    check(idle == exp_gap(), "R9", "gap completes after enable drop", idle, exp_gap());
    check(status == 2'd0, "R9", "returns to disabled", status, 0);
    saw = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_en) saw = 1;
    end
    check(!saw, "R9", "no further frame", saw, 0);
    enable = 1'b1;

    c_da = 48'hFFEEDDCCBBAA; c_plen = 45; c_L = 40; c_n = 2; c_D = 3;
    run_case(1);

    for (int k = 0; k < 6; k++) begin
      c_da = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      c_sa = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      c_et = 16'($urandom());
      c_tw = $urandom();
      c_tag = bit'($urandom_range(0, 1));
      c_plen = $urandom_range(42, 200);
      c_L = $urandom_range(20, 100);
      c_n = $urandom_range(1, 3);
      c_D = $urandom_range(0, 40);
      run_case(0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule